// File: doc/BRIEF.md
# Folded Symmetric FIR Delay Line

This block is the tapped delay structure of a folded FIR filter with symmetric coefficients. Samples run down a forward chain of eight programmable-length delay stages. A fold multiplexer picks one forward-path value and feeds it to the head of a reverse chain of eight more stages. Eight pre-adders each add one forward tap to the reverse tap that mirrors it. Each sum then needs only one multiplier, so eight multipliers serve a 16-tap (even) or 15-tap (odd) response. Every stage delays by the same number of samples, L, from 1 to 16. With L set to the number of interleaved channels, each channel's samples line up in the pre-adders without first being split into separate streams.

A plain multiply-accumulate against eight 12-bit coefficients follows the pre-adders. It stands in for the multiplier stage, so that the folded response can be checked. A small fill-tracking state machine with the states FILL and RUN raises `out_vld` once the chain holds only samples taken under the current configuration. Reset enters FILL. The transition FILL→RUN happens on the edge that takes in the 2·8·L-th sample since FILL was entered. The transition from any state to FILL happens on every configuration write. RUN otherwise holds.

In the odd-tap modes the centre sample reaches both inputs of the last pre-adder, so the centre coefficient must be programmed at half its value.

Top module: `fir_fold_line`

## Requirements
- R1: While and after reset, before any sample is taken: all delay stages hold zero, `out_vld` is 0, every pair is 0 and `mac_out` is 0. The configuration is even mode with L = 1.
- R2: In even mode, with h[d] the sample taken d samples ago, pair k = h[L(k+1)] + h[L(16−k)]. Even mode is selected when a configuration write has `cfg_odd` = 0.
- R3: In odd mode (`cfg_odd` = 1, `cfg_ilv` = 0), the reverse head is the value that leaves the last forward stage one sample later, so pair k = h[L(k+1)] + h[L(16−k)−1]. With L = 1, pair 7 is twice h[8].
- R4: In odd interleave mode (`cfg_odd` = 1, `cfg_ilv` = 1), the reverse head is the output of the next-to-last forward stage, so pair k = h[L(k+1)] + h[L(15−k)]. Pair 7 is twice h[8L] for every L.
- R5: `cfg_ilv` has no effect when a write has `cfg_odd` = 0; the block runs in even mode.
- R6: A configuration write takes L from `cfg_len`, with 0 taken as 1 and values above 16 taken as 16. The configuration inputs are ignored in cycles where `cfg_wr` is 0.
- R7: When `smp_vld` is 0 and no write occurs, no stage shifts, and the pairs and `mac_out` keep their values.
- R8: Samples are 12-bit two's complement. Each pre-adder adds exactly into 13 bits without saturating: two samples of 2047 give 4094 and two of −2048 give −4096.
- R9: `mac_out` = Σ coef_k · pair_k as a 28-bit signed value. Coefficient k is signed and sits in `coef_flat`[12k+11:12k]; pair k sits in `pair_flat`[13k+12:13k].
- R10: A configuration write clears `out_vld` on the next cycle and enters FILL. A sample taken in the same cycle as the write does not count toward the fill. `out_vld` rises on the edge that takes the 16·L-th sample counted since then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration inputs |
| cfg_odd | input | 1 | 0 = even tap count, 1 = odd tap count |
| cfg_ilv | input | 1 | With cfg_odd: select odd interleave fold |
| cfg_len | input | 5 | Stage length L (clamped to 1..16) |
| smp_vld | input | 1 | Take smp_in and advance all stages |
| smp_in | input | 12 | Signed input sample |
| coef_flat | input | 96 | Eight signed 12-bit coefficients |
| pair_flat | output | 104 | Eight signed 13-bit pre-added pairs |
| mac_out | output | 28 | Signed sum of coefficient times pair |
| out_vld | output | 1 | High in RUN: the chain holds only current-configuration samples |

## Verification
The checker watches several rules on every cycle. A write forces `out_vld` low on the next cycle and sets even mode when `cfg_odd` is clear. Mode and length never change without a write, and the length stays in range. The pairs hold still on idle cycles. `out_vld` rises only on a counted sample. In odd interleave mode the centre pair is always even. The exact tap arithmetic of each fold mode, the clamping of L, the overflow-free pre-add, the multiply-accumulate and the exact cycle on which the fill ends can only be shown by the bench: it keeps a history of the samples it has sent and computes each pair from it.

// File: rtl/fold_pkg.sv
package fold_pkg;

    typedef enum logic [1:0] {
        MD_EVEN    = 2'd0,
        MD_ODD     = 2'd1,
        MD_ODD_ILV = 2'd2
    } fold_mode_e;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } fill_state_e;

    function automatic int unsigned clamp_len(input int unsigned raw, input int unsigned top);
        if (raw == 0)  return 1;
        if (raw > top) return top;
        return raw;
    endfunction

    function automatic fold_mode_e decode_mode(input logic odd, input logic ilv);
        if (!odd) return MD_EVEN;
        if (ilv)  return MD_ODD_ILV;
        return MD_ODD;
    endfunction

endpackage

// File: rtl/fold_idr.sv
// Programmable-length delay stage: a len of 0 passes din straight through.
module fold_idr #(
    parameter int DW     = 12,
    parameter int MAXLEN = 16,
    localparam int LENW  = $clog2(MAXLEN + 1),
    localparam int IDXW  = (MAXLEN > 1) ? $clog2(MAXLEN) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [LENW-1:0]      len,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] dout
);
    logic signed [DW-1:0] sr [MAXLEN];
    logic [IDXW-1:0]      idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MAXLEN; i++) sr[i] <= '0;
        end else if (en) begin
            sr[0] <= din;
            for (int i = 1; i < MAXLEN; i++) sr[i] <= sr[i-1];
        end
    end

    assign idx  = IDXW'(len - LENW'(1));
    assign dout = (len == '0) ? din : sr[idx];
endmodule

// File: rtl/fold_mux.sv
// Fold-point multiplexer: picks the value that enters the reverse chain.
module fold_mux
    import fold_pkg::*;
#(
    parameter int DW = 12
) (
    input  fold_mode_e           mode,
    input  logic signed [DW-1:0] last_q,
    input  logic signed [DW-1:0] last_nx,
    input  logic signed [DW-1:0] prev_q,
    output logic signed [DW-1:0] head
);
    always_comb begin
        unique case (mode)
            MD_EVEN:    head = last_q;
            MD_ODD:     head = last_nx;
            MD_ODD_ILV: head = prev_q;
            default:    head = last_q;
        endcase
    end
endmodule

// File: rtl/fold_preadd.sv
// Pre-adders pairing mirrored taps, plus the check multiply-accumulate.
module fold_preadd #(
    parameter int DW   = 12,
    parameter int CW   = 12,
    parameter int NSTG = 8,
    parameter int ACCW = 28,
    localparam int PW    = DW + 1,
    localparam int PRODW = PW + CW
) (
    input  logic signed [DW-1:0]   fwd  [NSTG],
    input  logic signed [DW-1:0]   rev  [NSTG],
    input  logic signed [CW-1:0]   coef [NSTG],
    output logic signed [PW-1:0]   pair [NSTG],
    output logic signed [ACCW-1:0] mac
);
    logic signed [PRODW-1:0] prod [NSTG];

    for (genvar k = 0; k < NSTG; k++) begin : g_pair
        assign pair[k] = {fwd[k][DW-1], fwd[k]}
                       + {rev[NSTG-1-k][DW-1], rev[NSTG-1-k]};
        assign prod[k] = PRODW'(pair[k]) * PRODW'(coef[k]);
    end

    always_comb begin
        mac = '0;
        for (int k = 0; k < NSTG; k++) mac = mac + ACCW'(prod[k]);
    end
endmodule

// File: rtl/fold_ctrl.sv
// Configuration latch and the FILL/RUN tracker.
module fold_ctrl
    import fold_pkg::*;
#(
    parameter int NSTG   = 8,
    parameter int MAXLEN = 16,
    localparam int LENW  = $clog2(MAXLEN + 1),
    localparam int CNTW  = $clog2(2 * NSTG * MAXLEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic            cfg_odd,
    input  logic            cfg_ilv,
    input  logic [LENW-1:0] cfg_len,
    input  logic            smp_vld,
    output fold_mode_e      mode,
    output logic [LENW-1:0] len,
    output logic            out_vld
);
    fill_state_e     st, st_nx;
    logic [CNTW-1:0] cnt, tgt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= MD_EVEN;
            len  <= LENW'(1);
        end else if (cfg_wr) begin
            mode <= decode_mode(cfg_odd, cfg_ilv);
            len  <= LENW'(clamp_len(32'(cfg_len), MAXLEN));
        end
    end

    assign tgt = CNTW'(len) * CNTW'(2 * NSTG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt <= '0;
        else if (cfg_wr)                 cnt <= '0;
        else if (st == ST_FILL && smp_vld) cnt <= cnt + CNTW'(1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_FILL;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_FILL: if (smp_vld && cnt == tgt - CNTW'(1)) st_nx = ST_RUN;
            ST_RUN:  st_nx = ST_RUN;
        endcase
        if (cfg_wr) st_nx = ST_FILL;
    end

    // outputs
    always_comb begin
        out_vld = (st == ST_RUN);
    end
endmodule

// File: rtl/fir_fold_line.sv
module fir_fold_line
    import fold_pkg::*;
#(
    parameter int DW     = 12,
    parameter int CW     = 12,
    parameter int NSTG   = 8,
    parameter int MAXLEN = 16,
    localparam int LENW  = $clog2(MAXLEN + 1),
    localparam int PW    = DW + 1,
    localparam int ACCW  = PW + CW + $clog2(NSTG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic                   cfg_odd,
    input  logic                   cfg_ilv,
    input  logic [LENW-1:0]        cfg_len,
    input  logic                   smp_vld,
    input  logic signed [DW-1:0]   smp_in,
    input  logic [NSTG*CW-1:0]     coef_flat,
    output logic [NSTG*PW-1:0]     pair_flat,
    output logic signed [ACCW-1:0] mac_out,
    output logic                   out_vld
);
    fold_mode_e           mode;
    logic [LENW-1:0]      len, len_m1;
    logic signed [DW-1:0] fwd_in  [NSTG];
    logic signed [DW-1:0] fwd_out [NSTG];
    logic signed [DW-1:0] rev_in  [NSTG];
    logic signed [DW-1:0] rev_out [NSTG];
    logic signed [CW-1:0] coef    [NSTG];
    logic signed [PW-1:0] pair    [NSTG];
    logic signed [DW-1:0] head, last_nx;

    fold_ctrl #(.NSTG(NSTG), .MAXLEN(MAXLEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_odd(cfg_odd),
        .cfg_ilv(cfg_ilv), .cfg_len(cfg_len), .smp_vld(smp_vld),
        .mode(mode), .len(len), .out_vld(out_vld)
    );

    assign len_m1 = len - LENW'(1);

    for (genvar k = 0; k < NSTG; k++) begin : g_stg
        if (k == 0) begin : g_fin0
            assign fwd_in[k] = smp_in;
            assign rev_in[k] = head;
        end else begin : g_fin
            assign fwd_in[k] = fwd_out[k-1];
            assign rev_in[k] = rev_out[k-1];
        end

        if (k == NSTG - 1) begin : g_tail
            // last forward stage split: L-1 delay, then one register,
            // so the value about to leave it is available to the fold mux
            logic signed [DW-1:0] tail_q;
            fold_idr #(.DW(DW), .MAXLEN(MAXLEN)) u_pre (
                .clk(clk), .rst_n(rst_n), .en(smp_vld), .len(len_m1),
                .din(fwd_in[k]), .dout(last_nx)
            );
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       tail_q <= '0;
                else if (smp_vld) tail_q <= last_nx;
            end
            assign fwd_out[k] = tail_q;
        end else begin : g_body
            fold_idr #(.DW(DW), .MAXLEN(MAXLEN)) u_fwd (
                .clk(clk), .rst_n(rst_n), .en(smp_vld), .len(len),
                .din(fwd_in[k]), .dout(fwd_out[k])
            );
        end

        fold_idr #(.DW(DW), .MAXLEN(MAXLEN)) u_rev (
            .clk(clk), .rst_n(rst_n), .en(smp_vld), .len(len),
            .din(rev_in[k]), .dout(rev_out[k])
        );

        assign coef[k]               = coef_flat[k*CW +: CW];
        assign pair_flat[k*PW +: PW] = pair[k];
    end

    fold_mux #(.DW(DW)) u_mux (
        .mode(mode), .last_q(fwd_out[NSTG-1]), .last_nx(last_nx),
        .prev_q(fwd_out[NSTG-2]), .head(head)
    );

    fold_preadd #(.DW(DW), .CW(CW), .NSTG(NSTG), .ACCW(ACCW)) u_pre (
        .fwd(fwd_out), .rev(rev_out), .coef(coef), .pair(pair), .mac(mac_out)
    );
endmodule

// File: rtl/fir_fold_line_chk.sv
module fir_fold_line_chk
    import fold_pkg::*;
#(
    parameter int NSTG   = 8,
    parameter int PW     = 13,
    parameter int MAXLEN = 16,
    localparam int LENW  = $clog2(MAXLEN + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_wr,
    input logic               cfg_odd,
    input logic               smp_vld,
    input logic [NSTG*PW-1:0] pair_flat,
    input logic               out_vld,
    input fold_mode_e         mode,
    input logic [LENW-1:0]    len
);
    AST_VLD_DROP_ON_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !out_vld); // R10

    AST_VLD_RISE_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_vld) |-> ($past(smp_vld) && !$past(cfg_wr))); // R10

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld && !cfg_wr) |=> $stable(pair_flat)); // R7

    AST_EVEN_WHEN_NOT_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_odd) |=> (mode == MD_EVEN)); // R5

    AST_CFG_ONLY_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(mode) && $stable(len))); // R6

    AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (len >= LENW'(1)) && (len <= LENW'(MAXLEN))); // R6

    AST_ILV_CENTRE_DOUBLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && mode == MD_ODD_ILV) |-> !pair_flat[PW*(NSTG-1)]); // R4
endmodule

bind fir_fold_line fir_fold_line_chk #(.NSTG(NSTG), .PW(PW), .MAXLEN(MAXLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_odd(cfg_odd),
    .smp_vld(smp_vld), .pair_flat(pair_flat), .out_vld(out_vld),
    .mode(mode), .len(len)
);

// File: tb/fir_fold_line_tb.sv
`timescale 1ns/1ps
module fir_fold_line_tb;
    localparam int DW = 12, CW = 12, NSTG = 8, MAXLEN = 16;
    localparam int LENW = 5, PW = 13, ACCW = 28;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                   rst_n, cfg_wr, cfg_odd, cfg_ilv, smp_vld, out_vld;
    logic [LENW-1:0]        cfg_len;
    logic signed [DW-1:0]   smp_in;
    logic [NSTG*CW-1:0]     coef_flat;
    logic [NSTG*PW-1:0]     pair_flat;
    logic signed [ACCW-1:0] mac_out;

    fir_fold_line u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_odd(cfg_odd),
        .cfg_ilv(cfg_ilv), .cfg_len(cfg_len), .smp_vld(smp_vld),
        .smp_in(smp_in), .coef_flat(coef_flat), .pair_flat(pair_flat),
        .mac_out(mac_out), .out_vld(out_vld)
    );

    typedef struct {
        int     due;
        bit     vld;
        bit     chk;
        int     pr [NSTG];
        longint mac;
        string  tag;
    } exp_t;

    exp_t sbq[$];
    int   nchk = 0, nfail = 0, cyc = 0;
    int   hist [8192];
    int   npush = 0;
    int   coef_m [NSTG];
    bit   m_odd = 0, m_ilv = 0, m_vld = 0, cfg_seen = 0, done = 0;
    int   m_len = 1, m_cnt = 0;

    always @(posedge clk) cyc++;

    task automatic check(string tag, string what, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int h(int d);
        if (d < 1 || d > npush) return 0;
        return hist[npush - d];
    endfunction

    function automatic int exp_pair(int k);
        int b;
        if (!m_odd)     b = h(m_len * (16 - k));        // R2 / R5
        else if (m_ilv) b = h(m_len * (15 - k));        // R4
        else            b = h(m_len * (16 - k) - 1);    // R3
        return h(m_len * (k + 1)) + b;
    endfunction

    // driver: applies one cycle of stimulus and queues what must follow it
    task automatic step(bit vld, int smp, bit wr, bit odd, bit ilv, int len, string tag);
        exp_t e;
        @(negedge clk);
        smp_vld = vld; smp_in = DW'(smp); cfg_wr = wr;
        cfg_odd = odd; cfg_ilv = ilv; cfg_len = LENW'(len);
        for (int k = 0; k < NSTG; k++) coef_flat[k*CW +: CW] = CW'(coef_m[k]);
        if (wr) begin
            m_odd = odd; m_ilv = ilv;
            m_len = (len == 0) ? 1 : ((len > MAXLEN) ? MAXLEN : len);
            cfg_seen = 1; m_cnt = 0; m_vld = 0;
        end else if (vld && !m_vld) begin
            m_cnt++;
            if (m_cnt == 2 * NSTG * m_len) m_vld = 1;
        end
        if (vld) begin
            hist[npush] = smp;
            npush++;
        end
        e.due = cyc + 1; e.vld = m_vld; e.chk = m_vld || !cfg_seen;
        e.mac = 0; e.tag = tag;
        for (int k = 0; k < NSTG; k++) begin
            e.pr[k] = exp_pair(k);
            e.mac += longint'(coef_m[k]) * longint'(e.pr[k]);
        end
        sbq.push_back(e);
    endtask

    task automatic rnd_smp(output int s);
        s = int'($urandom_range(0, 4095)) - 2048;
    endtask

    // n sample cycles; config pins scrambled without a write (R6 ignore)
    task automatic push_n(int n, bit gaps, string tag);
        for (int i = 0; i < n; i++) begin
            int s;
            bit v;
            rnd_smp(s);
            v = gaps ? ($urandom_range(0, 3) != 0) : 1'b1;
            step(v, s, 1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, 31)), tag);
        end
    endtask

    // monitor
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            while (sbq.size() > 0 && sbq[0].due == cyc) begin
                e = sbq.pop_front();
                check("R10", "out_vld", longint'(out_vld), longint'(e.vld));
                if (e.chk) begin
                    for (int k = 0; k < NSTG; k++)
                        check(e.tag, $sformatf("pair%0d", k),
                              longint'($signed(pair_flat[k*PW +: PW])), longint'(e.pr[k]));
                    check("R9", "mac_out", longint'(mac_out), e.mac);
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL R10 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_wr = 0; cfg_odd = 0; cfg_ilv = 0; cfg_len = '0;
        smp_vld = 0; smp_in = '0;
        for (int k = 0; k < NSTG; k++) begin
            coef_m[k] = int'($urandom_range(0, 4095)) - 2048;
            coef_flat[k*CW +: CW] = CW'(coef_m[k]);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, nothing taken yet
        check("R1", "out_vld", longint'(out_vld), 0);
        for (int k = 0; k < NSTG; k++)
            check("R1", $sformatf("pair%0d", k), longint'($signed(pair_flat[k*PW +: PW])), 0);
        check("R1", "mac_out", longint'(mac_out), 0);

        push_n(40, 1'b0, "R2");                    // even, L=1 from reset
        for (int i = 0; i < 8; i++)                // R7: idle cycles
            step(1'b0, 5, 1'b0, 1'b1, 1'b1, 7, "R7");
        step(1'b0, 0, 1'b1, 1'b1, 1'b0, 1, "R10"); // odd, L=1 (drops out_vld)
        push_n(40, 1'b0, "R3");
        step(1'b0, 0, 1'b1, 1'b1, 1'b1, 3, "R10"); // odd interleave, L=3
        push_n(90, 1'b1, "R4");
        step(1'b0, 0, 1'b1, 1'b1, 1'b0, 2, "R10"); // odd, L=2
        push_n(50, 1'b0, "R3");
        step(1'b0, 0, 1'b1, 1'b0, 1'b1, 4, "R5");  // ilv ignored without odd
        push_n(80, 1'b0, "R5");
        step(1'b0, 0, 1'b1, 1'b0, 1'b0, 0, "R6");  // length 0 -> 1
        push_n(24, 1'b1, "R6");
        for (int k = 0; k < NSTG; k++) coef_m[k] = (k % 2 == 0) ? 2047 : -2048;
        for (int i = 0; i < 20; i++) step(1'b1, 2047, 1'b0, 1'b0, 1'b0, 0, "R8");
        for (int i = 0; i < 20; i++) step(1'b1, -2048, 1'b0, 1'b1, 1'b1, 9, "R8");
        for (int k = 0; k < NSTG; k++) coef_m[k] = int'($urandom_range(0, 4095)) - 2048;
        step(1'b0, 0, 1'b1, 1'b0, 1'b0, 20, "R6"); // length 20 -> 16
        push_n(280, 1'b0, "R6");
        step(1'b0, 0, 1'b1, 1'b1, 1'b0, 16, "R10"); // odd at maximum length
        push_n(270, 1'b0, "R3");
        step(1'b1, 100, 1'b1, 1'b1, 1'b1, 1, "R10"); // write with push: not counted
        push_n(20, 1'b0, "R4");
        repeat (3) step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, "R7");
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule